// File: doc/BRIEF.md
# Shared-Scale Floating Approximate Counter Array

This block keeps a small array of approximate counters in very little storage. Each entry holds a short estimation field and a short per-entry exponent, called the mode. One scale value is shared by the whole array. The estimate that entry `i` represents is `A[i] << (scale * mode[i])`. A weighted update names an entry and an increment. The increment is divided by the entry's current resolution. The divided value is added to the estimation field, and the bits that fall below the resolution are rounded up with a probability equal to their value. A free-running pseudo-random source supplies the comparison value for that rounding.

Overflow has two levels. If the estimation field passes its range, the entry's mode rises by one and the field is shifted right by the scale, again with probabilistic rounding. If the mode of an entry would pass its own range, the block walks the whole array and processes one entry per cycle. The walk recomputes every mode and shifts every estimation field so that each estimate is kept at the next larger scale, then raises the scale. While the walk runs, the input is stalled. A parameter set for which a rescale makes no progress, or a scale that cannot grow any further, is caught instead of looping. In that case a sticky error flag is set and the entry saturates. Software reads estimates through a combinational read port.

Top module: `sac_counter_array`

## Requirements
- R1: After reset every entry has estimation field 0 and mode 0, the scale is 1, `err` is 0 and `in_ready` is 1.
- R2: For the entry selected by `rd_idx`, `rd_est` equals `rd_a << (scale * rd_mode)`, `rd_a` is its estimation field and `rd_mode` is its mode.
- R3: An accepted update whose increment is a multiple of `2^(scale*mode)` adds exactly `inc >> (scale*mode)` to the field, provided the sum stays within `2^EST_W - 1`.
- R4: When the increment has a non-zero remainder below the resolution, the field grows by the floor of the quotient or by one more than that. The extra one is taken with probability equal to the remainder divided by `2^(scale*mode)`, and over repeated identical updates both outcomes occur.
- R5: If the sum passes `2^EST_W - 1` and the mode is below its maximum, the mode rises by one. The field becomes the sum shifted right by `scale`, rounded probabilistically and clipped at `2^EST_W - 1`.
- R6: If the sum overflows while the mode is already at `2^MODE_W - 1`, the block treats that entry's mode as `2^MODE_W` and runs a rescale. `in_ready` is held low for exactly `NUM_ENTRIES` cycles. During the rescale each entry's mode `m` becomes `m' = ceil(m*scale/(scale+1))` and its field is shifted right by `m'*(scale+1) - m*scale` with probabilistic rounding. At the end the scale rises by one.
- R7: With EST_W=5, MODE_W=2, scale 1, an entry at mode 3 with field 31 and an increment of 18 ends with scale 2, mode 2, field 16 or 17 (estimate 256 or 272). An entry at mode 1 with field 16 becomes mode 1, field 8. An entry at mode 0 is unchanged.
- R8: If the rescale would leave the triggering mode at `2^MODE_W`, or the scale is already at its maximum, no rescale runs. Instead `err` is set and stays set, the entry saturates to field `2^EST_W - 1` and mode `2^MODE_W - 1`, the scale is unchanged and `in_ready` stays high. With MODE_W=2 this first happens at scale 4.
- R9: An update changes only the entry named by `in_idx`, except during a rescale.
- R10: An update is taken on each clock edge with both `in_valid` and `in_ready` high. Holding `in_valid` for N cycles while ready applies N updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Update request |
| in_ready | output | 1 | Block can take an update (low during rescale) |
| in_idx | input | IDX_W | Entry to update |
| in_inc | input | INC_W | Increment weight |
| rd_idx | input | IDX_W | Entry to read |
| rd_est | output | EST_W+SHIFT_MAX | Estimate of the read entry |
| rd_a | output | EST_W | Estimation field of the read entry |
| rd_mode | output | MODE_W | Mode of the read entry |
| scale | output | SCALE_W | Shared scale |
| err | output | 1 | Sticky error: rescale cannot progress |

## Verification
The assertions check the following on every cycle:
- the scale only ever steps up by one, and only as the input becomes ready again;
- an accepted update moves the entry's mode by at most one;
- the error flag never clears and never coincides with a scale change;
- a rescale never raises a mode;
- a rounding shift never exceeds its random slice;
- the random source never locks up at zero.

Only the bench scenarios can show the arithmetic itself. These are the exact quotient additions, the overflow shift and clip, the exact stall length and per-entry results of a rescale, the worked case, and the collapse at scale 4. They also show that both rounding outcomes occur over repeated updates.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } sac_state_e;
endpackage

// File: rtl/sac_lfsr.sv
module sac_lfsr #(
  parameter int              STATE_W = 32,
  parameter int              OUT_W   = 28,
  parameter logic [STATE_W-1:0] TAPS = 32'hA300_0000,
  parameter logic [STATE_W-1:0] SEED = 32'h1D2C_3B4A
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign rnd = state_q[OUT_W-1:0];

  // random source must never lock up (supports R4)
  p_lfsr_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/sac_prob_round.sv
module sac_prob_round #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 21,
  parameter int SH_W   = 5
) (
  input  logic [IN_W-1:0]   value,
  input  logic [SH_W-1:0]   shift,
  input  logic [FRAC_W-1:0] rnd,
  output logic [IN_W-1:0]   floor_o,
  output logic              round_up
);
  localparam int XW = IN_W + FRAC_W;

  logic [XW-1:0]     ext;
  logic [XW-1:0]     mask;
  logic [FRAC_W-1:0] frac;
  logic [FRAC_W-1:0] rnd_m;

  always_comb begin
    ext      = XW'(value);
    mask     = (XW'(1) << shift) - XW'(1);
    frac     = FRAC_W'(ext & mask);
    rnd_m    = rnd & FRAC_W'(mask);
    floor_o  = IN_W'(ext >> shift);
    round_up = frac > rnd_m;
  end

  // the shift must fit inside the random slice, else probabilities skew (R4)
  always_comb begin
    if (!$isunknown(shift))
      p_shift_fits_r4: assert (int'(shift) <= FRAC_W);
  end
endmodule

// File: rtl/sac_renorm_calc.sv
module sac_renorm_calc #(
  parameter int MODE_W  = 2,
  parameter int SCALE_W = 3
) (
  input  logic [MODE_W:0]    mode_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [MODE_W:0]    mode_o,
  output logic [SCALE_W-1:0] shift_o
);
  localparam int PW   = MODE_W + SCALE_W + 2;
  localparam int MW1  = MODE_W + 1;
  localparam int MLIM = 1 << MODE_W;

  logic [PW-1:0] target;
  logic [PW-1:0] step;

  always_comb begin
    target = PW'(mode_i) * PW'(scale_i);
    step   = PW'(scale_i) + PW'(1);
    mode_o = MW1'(MLIM);
    for (int k = MLIM; k >= 0; k--) begin
      if (PW'(k) * step >= target) mode_o = MW1'(k);
    end
    shift_o = SCALE_W'(PW'(mode_o) * step - target);
  end

  // a rescale never raises a mode (R6)
  always_comb begin
    if (!$isunknown(mode_i) && !$isunknown(scale_i))
      p_mode_shrink_r6: assert (mode_o <= mode_i);
  end
endmodule

// File: rtl/sac_counter_array.sv
module sac_counter_array
  import sac_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int EST_W       = 5,
  parameter int MODE_W      = 2,
  parameter int SCALE_W     = 3,
  parameter int INC_W       = 16,
  parameter int INIT_SCALE  = 1,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int RMAX       = (1 << SCALE_W) - 1,
  localparam int MODE_MAX   = (1 << MODE_W) - 1,
  localparam int SHIFT_MAX  = RMAX * MODE_MAX,
  localparam int EST_OUT_W  = EST_W + SHIFT_MAX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IDX_W-1:0]     in_idx,
  input  logic [INC_W-1:0]     in_inc,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [EST_OUT_W-1:0] rd_est,
  output logic [EST_W-1:0]     rd_a,
  output logic [MODE_W-1:0]    rd_mode,
  output logic [SCALE_W-1:0]   scale,
  output logic                 err
);
  localparam int SHIFT_W = $clog2(SHIFT_MAX + 1);
  localparam int SUM_W   = ((INC_W > EST_W) ? INC_W : EST_W) + 1;
  localparam int RND_W   = SHIFT_MAX + RMAX;
  localparam int AMAX    = (1 << EST_W) - 1;
  localparam int MLIM    = 1 << MODE_W;

  // ---------------- state ----------------
  logic [EST_W-1:0]  est_q  [NUM_ENTRIES];
  logic [MODE_W-1:0] mode_q [NUM_ENTRIES];
  logic [SCALE_W-1:0] scale_q, scale_d;
  logic               err_q, err_d;
  sac_state_e         state_q, state_d;
  logic [IDX_W-1:0]   walk_q, walk_d;
  logic [IDX_W-1:0]   trig_q, trig_d;

  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [EST_W-1:0]   wr_a;
  logic [MODE_W-1:0]  wr_mode;

  // ---------------- random source ----------------
  logic [RND_W-1:0]   rnd;
  logic [SHIFT_MAX-1:0] rnd_inc;
  logic [RMAX-1:0]      rnd_shr;

  sac_lfsr #(.STATE_W(32), .OUT_W(RND_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  assign rnd_inc = rnd[SHIFT_MAX-1:0];
  assign rnd_shr = rnd[SHIFT_MAX +: RMAX];

  // ---------------- entry select ----------------
  logic               walking;
  logic               acc;
  logic [IDX_W-1:0]   sel_idx;
  logic [EST_W-1:0]   ent_a;
  logic [MODE_W-1:0]  ent_m;
  logic [SHIFT_W-1:0] inc_shift;

  assign walking  = (state_q == ST_WALK);
  assign in_ready = !walking;
  assign acc      = in_valid && in_ready;
  assign sel_idx  = walking ? walk_q : in_idx;
  assign ent_a    = est_q[sel_idx];
  assign ent_m    = mode_q[sel_idx];
  assign inc_shift = SHIFT_W'(scale_q) * SHIFT_W'(ent_m);

  // ---------------- increment path ----------------
  logic [INC_W-1:0] inc_floor;
  logic             inc_up;
  logic [SUM_W-1:0] sum;
  logic             est_ovf;

  sac_prob_round #(.IN_W(INC_W), .FRAC_W(SHIFT_MAX), .SH_W(SHIFT_W)) u_inc_round (
    .value(in_inc), .shift(inc_shift), .rnd(rnd_inc),
    .floor_o(inc_floor), .round_up(inc_up)
  );

  assign sum     = SUM_W'(ent_a) + SUM_W'(inc_floor) + SUM_W'(inc_up);
  assign est_ovf = sum > SUM_W'(AMAX);

  // ---------------- estimation-overflow shift ----------------
  logic [SUM_W-1:0] ov_floor;
  logic             ov_up;
  logic [SUM_W:0]   ov_val;
  logic [EST_W-1:0] ov_clip;

  sac_prob_round #(.IN_W(SUM_W), .FRAC_W(RMAX), .SH_W(SHIFT_W)) u_ovf_round (
    .value(sum), .shift(SHIFT_W'(scale_q)), .rnd(rnd_shr),
    .floor_o(ov_floor), .round_up(ov_up)
  );

  assign ov_val  = (SUM_W+1)'(ov_floor) + (SUM_W+1)'(ov_up);
  assign ov_clip = (ov_val > (SUM_W+1)'(AMAX)) ? EST_W'(AMAX) : ov_val[EST_W-1:0];

  // ---------------- rescale arithmetic ----------------
  logic [MODE_W:0]    ren_m_in;
  logic [MODE_W:0]    ren_m_out;
  logic [SCALE_W-1:0] ren_shift;
  logic [EST_W-1:0]   ren_floor;
  logic               ren_up;
  logic               collapse;

  // in idle the calculator looks at the would-be trigger; in the walk at the current entry
  assign ren_m_in = (!walking || (walk_q == trig_q)) ? (MODE_W+1)'(MLIM)
                                                      : {1'b0, ent_m};

  sac_renorm_calc #(.MODE_W(MODE_W), .SCALE_W(SCALE_W)) u_calc (
    .mode_i(ren_m_in), .scale_i(scale_q),
    .mode_o(ren_m_out), .shift_o(ren_shift)
  );

  sac_prob_round #(.IN_W(EST_W), .FRAC_W(RMAX), .SH_W(SHIFT_W)) u_ren_round (
    .value(ent_a), .shift(SHIFT_W'(ren_shift)), .rnd(rnd_shr),
    .floor_o(ren_floor), .round_up(ren_up)
  );

  assign collapse = (ren_m_out == (MODE_W+1)'(MLIM)) || (scale_q == SCALE_W'(RMAX));

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    walk_d  = walk_q;
    trig_d  = trig_q;
    scale_d = scale_q;
    err_d   = err_q;
    wr_en   = 1'b0;
    wr_idx  = sel_idx;
    wr_a    = ent_a;
    wr_mode = ent_m;
    if (walking) begin
      wr_en   = 1'b1;
      wr_a    = ren_floor + EST_W'(ren_up);
      wr_mode = ren_m_out[MODE_W-1:0];
      walk_d  = walk_q + IDX_W'(1);
      if (walk_q == IDX_W'(NUM_ENTRIES - 1)) begin
        state_d = ST_IDLE;
        walk_d  = '0;
        scale_d = scale_q + SCALE_W'(1);
      end
    end else if (acc) begin
      wr_en = 1'b1;
      if (!est_ovf) begin
        wr_a = sum[EST_W-1:0];
      end else if (ent_m != MODE_W'(MODE_MAX)) begin
        wr_a    = ov_clip;
        wr_mode = ent_m + MODE_W'(1);
      end else if (collapse) begin
        wr_a    = EST_W'(AMAX);
        wr_mode = MODE_W'(MODE_MAX);
        err_d   = 1'b1;
      end else begin
        wr_a    = ov_clip;
        state_d = ST_WALK;
        walk_d  = '0;
        trig_d  = in_idx;
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      walk_q  <= '0;
      trig_q  <= '0;
      scale_q <= SCALE_W'(INIT_SCALE);
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      walk_q  <= walk_d;
      trig_q  <= trig_d;
      scale_q <= scale_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        est_q[i]  <= '0;
        mode_q[i] <= '0;
      end
    end else if (wr_en) begin
      est_q[wr_idx]  <= wr_a;
      mode_q[wr_idx] <= wr_mode;
    end
  end

  // ---------------- read port ----------------
  assign rd_a    = est_q[rd_idx];
  assign rd_mode = mode_q[rd_idx];
  assign rd_est  = EST_OUT_W'(rd_a) << (SHIFT_W'(scale_q) * SHIFT_W'(rd_mode));
  assign scale   = scale_q;
  assign err     = err_q;

  // ---------------- assertions ----------------
  p_scale_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_q != $past(scale_q)) |-> (scale_q == $past(scale_q) + SCALE_W'(1)));

  p_scale_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_q != $past(scale_q)) |-> in_ready);

  p_mode_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((mode_q[$past(in_idx)] == $past(ent_m)) ||
             (mode_q[$past(in_idx)] == $past(ent_m) + MODE_W'(1))));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  p_err_no_scale_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $stable(scale_q));
endmodule

// File: tb/tb_sac_counter_array.sv
module tb_sac_counter_array;
  localparam int N  = 8;
  localparam int IW = 3;

  logic        clk, rst_n;
  logic        in_valid, in_ready;
  logic [IW-1:0] in_idx, rd_idx;
  logic [15:0] in_inc;
  logic [25:0] rd_est;
  logic [4:0]  rd_a;
  logic [1:0]  rd_mode;
  logic [2:0]  scale;
  logic        err;

  int checks, failures;
  bit done;

  sac_counter_array dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .in_inc(in_inc), .rd_idx(rd_idx), .rd_est(rd_est),
    .rd_a(rd_a), .rd_mode(rd_mode), .scale(scale), .err(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_idx = '0; in_inc = '0; rd_idx = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input int idx, input int inc);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_idx = IW'(idx); in_inc = 16'(inc);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic peek(input int idx);
    rd_idx = IW'(idx);
    #1;
  endtask

  task automatic wait_ready();
    while (!in_ready) @(negedge clk);
  endtask

  // one exact step toward mode 3 / field 31, or one unit beyond it
  task automatic push_unit(input int idx);
    int unit, n;
    peek(idx);
    unit = 1 << (int'(scale) * int'(rd_mode));
    if (rd_a < 31) begin
      n = 31 - int'(rd_a);
      if (n > 15) n = 15;
      send(idx, unit * n);
    end else begin
      send(idx, unit);
    end
    wait_ready();
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(scale == 3'd1, "R1 scale", scale, 1);
    chk(err == 1'b0, "R1 err", err, 0);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    for (int i = 0; i < N; i++) begin
      peek(i);
      chk(rd_a == 0 && rd_mode == 0, "R1 entry cleared", rd_a, 0);
    end
  endtask

  task automatic t_exact_add();
    do_reset();
    send(0, 5);
    peek(0);
    chk(rd_a == 5, "R3 exact add", rd_a, 5);
    chk(rd_est == 5, "R2 estimate", rd_est, 5);
    // R10: hold valid three cycles, three updates
    in_valid = 1'b1; in_idx = 3'd1; in_inc = 16'd2;
    repeat (3) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R10 ready stays high", in_ready, 1);
    end
    in_valid = 1'b0;
    peek(1);
    chk(rd_a == 6, "R10 back-to-back updates", rd_a, 6);
    peek(0);
    chk(rd_a == 5, "R9 other entry untouched", rd_a, 5);
    peek(7);
    chk(rd_a == 0 && rd_mode == 0, "R9 idle entry untouched", rd_a, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    send(2, 31);
    send(2, 1);
    peek(2);
    chk(rd_mode == 1, "R5 mode raised", rd_mode, 1);
    chk(rd_a == 16, "R5 field shifted", rd_a, 16);
    send(2, 4);
    peek(2);
    chk(rd_a == 18, "R3 add at mode 1", rd_a, 18);
    chk(rd_est == 36, "R2 estimate at mode 1", rd_est, 36);
    send(3, 31);
    send(3, 255);
    peek(3);
    chk(rd_a == 31 && rd_mode == 1, "R5 clip", rd_a, 31);
    chk(rd_est == 62, "R2 estimate after clip", rd_est, 62);
  endtask

  task automatic t_rounding();
    int ups, prev, d;
    do_reset();
    send(6, 31);
    send(6, 1);
    ups = 0;
    peek(6);
    prev = int'(rd_a);
    for (int i = 0; i < 10; i++) begin
      send(6, 1);
      peek(6);
      d = int'(rd_a) - prev;
      chk(d == 0 || d == 1, "R4 floor or floor+1", d, 0);
      ups += d;
      prev = int'(rd_a);
    end
    chk(ups > 0 && ups < 10, "R4 both outcomes seen", ups, 5);
  endtask

  task automatic t_renorm_walk();
    int low, guard;
    do_reset();
    send(0, 10);
    send(1, 31);
    send(1, 1);
    guard = 0;
    peek(5);
    while (!(rd_mode == 3 && rd_a == 31) && guard < 40) begin
      push_unit(5);
      peek(5);
      guard++;
    end
    chk(rd_mode == 3 && rd_a == 31, "R7 setup reached", rd_a, 31);
    send(5, 18);
    low = 0;
    while (!in_ready && low < 100) begin
      low++;
      @(negedge clk);
    end
    chk(low == N, "R6 stall length", low, N);
    chk(scale == 3'd2, "R6 scale raised", scale, 2);
    peek(5);
    chk(rd_mode == 2, "R7 trigger mode", rd_mode, 2);
    chk(rd_a == 16 || rd_a == 17, "R7 trigger field", rd_a, 17);
    chk(rd_est == 256 || rd_est == 272, "R7 trigger estimate", rd_est, 272);
    peek(1);
    chk(rd_a == 8 && rd_mode == 1, "R6 mode-1 entry rescaled", rd_a, 8);
    chk(rd_est == 32, "R6 estimate kept", rd_est, 32);
    peek(0);
    chk(rd_a == 10 && rd_mode == 0, "R6 mode-0 entry kept", rd_a, 10);
  endtask

  task automatic t_collapse();
    int guard;
    do_reset();
    guard = 0;
    while (scale != 3'd4 && guard < 200) begin
      push_unit(4);
      guard++;
    end
    chk(scale == 3'd4, "R8 reached scale 4", scale, 4);
    chk(err == 1'b0, "R8 no error yet", err, 0);
    guard = 0;
    while (!err && guard < 40) begin
      push_unit(4);
      guard++;
    end
    chk(err == 1'b1, "R8 error raised", err, 1);
    chk(scale == 3'd4, "R8 scale unchanged", scale, 4);
    chk(in_ready == 1'b1, "R8 no stall", in_ready, 1);
    peek(4);
    chk(rd_a == 31 && rd_mode == 3, "R8 saturated", rd_a, 31);
    send(4, 4096);
    chk(err == 1'b1, "R8 error sticky", err, 1);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    t_reset_state();
    t_exact_add();
    t_overflow();
    t_rounding();
    t_renorm_walk();
    t_collapse();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule